// File: doc/BRIEF.md
# Multiplexed Four-Digit Hex Display Scanner

This block drives a four-digit seven-segment display in which all digits share one set of segment lines and each digit has its own enable line. Because only one digit can be lit at a time, the block scans the digits in turn, fast enough that the eye sees all four at once. A free-running binary counter divides the system clock. The level of a slow scan signal flips each time that counter wraps. On every rising step of the scan level, a one-hot-low digit select moves to the next digit.

For the digit currently selected, combinational logic picks a 4-bit value and converts it to a hexadecimal glyph. The two leftmost digits always show the letters E and A. The two rightmost digits show the upper and lower nibbles of an 8-bit switch input. Segment lines and digit enables are both active-low and leave the block from one register stage, so they always change together. The decimal point is kept dark.

Top module: `hexscan_display`

## Requirements
- R1: Reset is synchronous and active-high. On the clock edge after reset is sampled high, all four digit enables and all seven segment lines read 1 (dark). On the first clock edge after reset is released, the enables read 1110, selecting the rightmost digit.
- R2: At most one bit of the digit-enable output is 0 in any cycle.
- R3: The digit-enable output steps through 1110, 1101, 1011, 0111 and then back to 1110. Bit 0 is the rightmost digit and bit 3 the leftmost.
- R4: A DIV_BITS-wide counter counts every cycle, and a scan level toggles each time the counter wraps from all ones to zero. The select advances when the scan level rises. The first digit after reset is held for 2^DIV_BITS cycles, and every later digit for 2^(DIV_BITS+1) cycles (2048 with the default DIV_BITS of 10).
- R5: While enable pattern 0111 is active, the segments show the glyph for value 14 (E). While 1011 is active, they show the glyph for value 10 (A).
- R6: While 1101 is active, the segments show the glyph of switch bits 7..4. While 1110 is active, they show the glyph of switch bits 3..0.
- R7: The segment output is ordered {g,f,e,d,c,b,a} from bit 6 down to bit 0, and 0 means lit. The hex glyphs in that encoding are 0:40 1:79 2:24 3:30 4:19 5:12 6:02 7:78 8:00 9:10 A:08 b:03 C:46 d:21 E:06 F:0E.
- R8: The decimal-point output is always 1.
- R9: The segment output and the digit enables come from one register stage and change on the same clock edge. In every cycle, the segment pattern is the one belonging to the digit enabled in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | 8 | Switch value; bits 7..4 feed digit 1 and bits 3..0 feed digit 0 |
| seg_n | output | 7 | Active-low segment lines {g,f,e,d,c,b,a} |
| dp_n | output | 1 | Active-low decimal point, held dark |
| dig_n | output | 4 | Active-low digit enables, bit 0 rightmost |

## Verification
Every nibble value from 0 to F is sent through both switch-fed digits. The segment output is compared against the enabled digit in every cycle, so several kinds of fault show up as mismatches:
- a swapped nibble pair, a reversed scan direction or a wrong glyph;
- segments that lag the enables by one cycle, which would appear as a stale glyph at each digit boundary.

The time each digit stays enabled is measured against the full scan period and against the half period of the first digit after reset. A divider that advanced on both scan edges, or on every wrap, would produce dwells that are too short. A reset applied in the middle of a scan must blank the display and restart it at the rightmost digit, not resume from where it stopped.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;

  localparam int DIGITS      = 4;
  localparam int NIB_W       = 4;
  localparam int SEG_W       = 7;
  localparam int LIVE_DIGITS = 2;
  localparam int SW_W        = LIVE_DIGITS * NIB_W;

  typedef logic [NIB_W-1:0]  nibble_t;
  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [DIGITS-1:0] sel_t;

  localparam nibble_t CHAR_LEFT   = 4'hE;
  localparam nibble_t CHAR_SECOND = 4'hA;
  localparam seg_t    SEG_DARK    = '1;
  localparam sel_t    SEL_NONE    = '1;
  localparam sel_t    SEL_FIRST   = {{(DIGITS-1){1'b1}}, 1'b0};

  // Constant nibble for a digit position that is not fed by the switches.
  function automatic nibble_t fixed_nibble(input int idx);
    if (idx == DIGITS - 1) return CHAR_LEFT;
    return CHAR_SECOND;
  endfunction

  // Hex glyph, bit order {g,f,e,d,c,b,a}, 0 lights a segment.
  function automatic seg_t hex_to_seg_n(input nibble_t v);
    seg_t lit;
    case (v)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction

endpackage

// File: rtl/scan_divider.sv
module scan_divider #(
  parameter int DIV_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  output logic step
);

  logic [DIV_BITS-1:0] count_q;
  logic                scan_lvl_q;
  logic                wrap;

  assign wrap = &count_q;
  // Rising step of the scan level: the wrap that flips it from 0 to 1.
  assign step = wrap & ~scan_lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      scan_lvl_q <= 1'b0;
    end else begin
      count_q <= count_q + 1'b1;
      if (wrap) scan_lvl_q <= ~scan_lvl_q;
    end
  end

endmodule

// File: rtl/digit_ring.sv
module digit_ring
  import hexscan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  output sel_t sel_n
);

  sel_t ring_q;

  always_ff @(posedge clk) begin
    if (rst)       ring_q <= SEL_FIRST;
    else if (step) ring_q <= {ring_q[DIGITS-2:0], ring_q[DIGITS-1]};
  end

  assign sel_n = ring_q;

endmodule

// File: rtl/glyph_select.sv
module glyph_select
  import hexscan_pkg::*;
(
  input  sel_t            sel_n,
  input  logic [SW_W-1:0] sw,
  output seg_t            seg_n
);

  nibble_t masked [DIGITS];
  nibble_t picked;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    nibble_t src;
    if (i < LIVE_DIGITS) begin : g_live
      assign src = sw[i*NIB_W +: NIB_W];
    end else begin : g_fixed
      assign src = fixed_nibble(i);
    end
    assign masked[i] = sel_n[i] ? '0 : src;
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < DIGITS; i++) picked = picked | masked[i];
  end

  assign seg_n = hex_to_seg_n(picked);

endmodule

// File: rtl/hexscan_display.sv
module hexscan_display #(
  parameter int DIV_BITS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sw,
  output logic [6:0] seg_n,
  output logic       dp_n,
  output logic [3:0] dig_n
);
  import hexscan_pkg::*;

  logic step;
  sel_t sel_n;
  seg_t seg_next;
  seg_t seg_q;
  sel_t dig_q;

  scan_divider #(.DIV_BITS(DIV_BITS)) u_div (
    .clk  (clk),
    .rst  (rst),
    .step (step)
  );

  digit_ring u_ring (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .sel_n (sel_n)
  );

  glyph_select u_glyph (
    .sel_n (sel_n),
    .sw    (sw),
    .seg_n (seg_next)
  );

  // One register stage for enables and segments together.
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= SEG_DARK;
      dig_q <= SEL_NONE;
    end else begin
      seg_q <= seg_next;
      dig_q <= sel_n;
    end
  end

  assign seg_n = seg_q;
  assign dig_n = dig_q;
  assign dp_n  = 1'b1;

endmodule

// File: rtl/hexscan_checker.sv
module hexscan_checker #(
  parameter int DIV_BITS = 10
) (
  input logic       clk,
  input logic       rst,
  input logic [6:0] seg_n,
  input logic       dp_n,
  input logic [3:0] dig_n
);
  localparam int PERIOD = 1 << (DIV_BITS + 1);

  logic [3:0]          prev_dig;
  logic [DIV_BITS+1:0] dwell;
  logic [1:0]          nchg;
  logic                rst_d;
  logic                chg;

  assign chg = (dig_n != prev_dig);

  always_ff @(posedge clk) begin
    if (rst_d) begin
      a_r1_dark_after_reset: assert (dig_n == 4'hF && seg_n == 7'h7F);
    end
    rst_d <= rst;
    if (rst) begin
      prev_dig <= 4'hF;
      dwell    <= '0;
      nchg     <= '0;
    end else begin
      prev_dig <= dig_n;
      if (chg) begin
        dwell <= 1;
        if (nchg != 2'd3) nchg <= nchg + 1'b1;
      end else begin
        dwell <= dwell + 1'b1;
      end
    end
  end

  a_r2_one_digit: assert property (@(posedge clk) disable iff (rst)
    $countones(~dig_n) <= 1);

  a_r3_rotate: assert property (@(posedge clk) disable iff (rst)
    (chg && prev_dig != 4'hF) |-> dig_n == {prev_dig[2:0], prev_dig[3]});

  a_r4_dwell: assert property (@(posedge clk) disable iff (rst)
    (chg && nchg >= 2'd2) |-> int'(dwell) == PERIOD);

  a_r5_left_e: assert property (@(posedge clk) disable iff (rst)
    dig_n == 4'b0111 |-> seg_n == 7'h06);

  a_r5_second_a: assert property (@(posedge clk) disable iff (rst)
    dig_n == 4'b1011 |-> seg_n == 7'h08);

  a_r8_dp_dark: assert property (@(posedge clk) disable iff (rst)
    dp_n == 1'b1);

endmodule

bind hexscan_display hexscan_checker #(.DIV_BITS(DIV_BITS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .seg_n (seg_n),
  .dp_n  (dp_n),
  .dig_n (dig_n)
);

// File: tb/test_hexscan_display.sv
module test_hexscan_display;
  localparam int DIV = 4;
  localparam int PER = 1 << (DIV + 1);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sw  = 8'h10;
  logic [6:0] seg_n;
  logic       dp_n;
  logic [3:0] dig_n;

  typedef struct packed { logic [3:0] dig; logic [6:0] seg; } item_t;
  item_t q[$];
  item_t cur;
  int compared = 0, mismatched = 0;
  int nchg = 0, dwell = 0;
  logic [3:0] prev = 4'hF;
  bit done = 0;

  hexscan_display #(.DIV_BITS(DIV)) i_hexscan_display (
    .clk(clk), .rst(rst), .sw(sw), .seg_n(seg_n), .dp_n(dp_n), .dig_n(dig_n));

  always #5 clk = ~clk;

  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'h0: return 7'h40; 4'h1: return 7'h79; 4'h2: return 7'h24; 4'h3: return 7'h30;
      4'h4: return 7'h19; 4'h5: return 7'h12; 4'h6: return 7'h02; 4'h7: return 7'h78;
      4'h8: return 7'h00; 4'h9: return 7'h10; 4'hA: return 7'h08; 4'hB: return 7'h03;
      4'hC: return 7'h46; 4'hD: return 7'h21; 4'hE: return 7'h06; default: return 7'h0E;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic push_rotation(input logic [7:0] s);
    q.push_back('{dig: 4'b1110, seg: glyph(s[3:0])});
    q.push_back('{dig: 4'b1101, seg: glyph(s[7:4])});
    q.push_back('{dig: 4'b1011, seg: glyph(4'hA)});
    q.push_back('{dig: 4'b0111, seg: glyph(4'hE)});
  endtask

  // Change the switches while the leftmost (switch-independent) digit shows.
  task automatic apply(input logic [7:0] s);
    @(negedge clk);
    while (dig_n != 4'b0111) @(negedge clk);
    sw = s;
    push_rotation(s);
    while (dig_n == 4'b0111) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      nchg = 0; dwell = 0; prev = 4'hF;
    end else begin
      if (dig_n != prev && dig_n != 4'hF) begin
        nchg++;
        if (nchg == 2) check(dwell == PER / 2, "R4 first dwell", dwell, PER / 2);
        if (nchg >= 3) check(dwell == PER, "R4 dwell", dwell, PER);
        dwell = 0;
        if (q.size() == 0) check(1'b0, "R3 unexpected digit step", dig_n, 0);
        else cur = q.pop_front();
      end
      dwell++;
      prev = dig_n;
      check($countones(~dig_n) <= 1, "R2 one digit", dig_n, 0);
      check(dp_n == 1'b1, "R8 dp", dp_n, 1);
      if (dig_n != 4'hF) begin
        check(dig_n == cur.dig, "R3 order", dig_n, cur.dig);
        if (dig_n[3] == 1'b0 || dig_n[2] == 1'b0)
          check(seg_n == cur.seg, "R5 R7 R9 fixed glyph", seg_n, cur.seg);
        else
          check(seg_n == cur.seg, "R6 R7 R9 switch glyph", seg_n, cur.seg);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [9] = '{8'h32, 8'h54, 8'h76, 8'h98, 8'hBA, 8'hDC, 8'hFE, 8'h0F, 8'hA5};
    push_rotation(sw);
    repeat (3) @(negedge clk);
    check(dig_n == 4'hF, "R1 reset enables", dig_n, 4'hF);
    check(seg_n == 7'h7F, "R1 reset segments", seg_n, 7'h7F);
    rst = 1'b0;
    @(negedge clk);
    check(dig_n == 4'b1110, "R1 first digit", dig_n, 4'b1110);
    foreach (pats[i]) apply(pats[i]);
    // mid-scan reset
    @(negedge clk);
    while (dig_n != 4'b1011) @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    q.delete();
    push_rotation(sw);
    repeat (2) @(negedge clk);
    check(dig_n == 4'hF, "R1 mid reset enables", dig_n, 4'hF);
    check(seg_n == 7'h7F, "R1 mid reset segments", seg_n, 7'h7F);
    rst = 1'b0;
    @(negedge clk);
    check(dig_n == 4'b1110, "R1 restart digit", dig_n, 4'b1110);
    while (dig_n != 4'b0111) @(negedge clk);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R3 queue drained", q.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule